// File: doc/BRIEF.md
# External Interrupt Controller

This block collects three external interrupt pins for a small microcontroller core and turns them into prioritised interrupt requests. Each pin is brought into the clock domain by a two-flop synchroniser and then tested against a condition chosen by software. Pins 0 and 1 can each be set to one of four conditions: low level, any change, falling edge or rising edge. Pin 2 reacts only to edges, and a single polarity bit chooses which edge.

Software reaches four byte-wide registers over a simple read/write bus: a per-pin enable register, a sense-mode register for pins 0 and 1, a control register holding the pin 2 polarity bit, and a pending-flag register. In the three edge-type modes a detected condition sets a pending flag. Software clears a flag by writing a one to it, or the core clears it with a service acknowledge. In low-level mode no flag is latched: the request follows the synchronised pin.

A pin's request is its source (the flag, or the active low level) ANDed with that pin's enable and with the global interrupt enable. A fixed-priority encoder reports which request to serve first.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, all four registers (enable at address 0, sense at 1, control at 2, flags at 3) read 0x00, and no request is raised.
- R2: The enable register holds pin 1 at bit 7, pin 0 at bit 6 and pin 2 at bit 5. These bits can be read and written. Bits 4..0 read as 0, so writing 0xFF reads back 0xE0. A pin raises no request while its enable bit is 0.
- R3: The sense register uses bits 1:0 for pin 0 and bits 3:2 for pin 1, and bits 7:4 read as 0. Code 01 sets the flag on any change, code 10 on a falling edge and code 11 on a rising edge. An edge of the other polarity does not set the flag in a single-edge mode.
- R4: With sense code 00, the pin's request follows the synchronised pin while it is low. No flag is latched, and an acknowledge does not remove the request.
- R5: Pin 2 is edge-only. Control bit 6 selects the edge: 0 means falling and 1 means rising. The other control bits read as 0.
- R6: The flag register holds pin 1 at bit 7, pin 0 at bit 6 and pin 2 at bit 5. Writing 1 to a flag bit clears that flag. Writing 0 leaves it unchanged.
- R7: A request is raised only while the global interrupt enable input is high.
- R8: An acknowledge pulse with a pin index (0, 1 or 2) clears that pin's flag. If a new condition on the same pin lands in the same cycle, the flag stays set.
- R9: When several requests are active, the reported index is the lowest-numbered active pin: pin 0 first, then pin 1, then pin 2. The index is valid only while the any-request output is high.
- R10: Changing a sense code or the pin 2 polarity while the pin is steady does not set a flag.
- R11: A pin change sets its flag on the third rising clock edge after it is applied, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_i | input | 3 | Asynchronous external pins, index = pin number |
| global_ie | input | 1 | Global interrupt enable from the core |
| ack_valid | input | 1 | One-cycle service acknowledge |
| ack_idx | input | 2 | Pin index being acknowledged |
| irq_req | output | 3 | Per-pin gated request |
| irq_any | output | 1 | At least one request is active |
| irq_idx | output | 2 | Highest-priority active pin |

## Verification
The assertions assume that the pins idle high through reset, which is the reset value of the synchroniser and edge history. They also assume that ack_idx never carries the unused code 3 while ack_valid is high. The bench holds every pin high until reset has been released and acknowledges only pins 0 to 2. It changes pins, bus signals and acknowledges only on falling clock edges, so each synchroniser stage and each register update falls on a known rising edge. The collision case is timed so that the acknowledge and the detected edge meet on the same rising edge.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int NPIN   = 3;
    localparam int NLVL   = 2;
    localparam int IDX_W  = $clog2(NPIN);
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_EN    = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_SENSE = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_FLAG  = 2'd3;

    localparam int POL_BIT = 6;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef struct packed {
        logic [NPIN-1:0]   en;
        logic [2*NLVL-1:0] sense;
        logic              pol2;
        logic [NPIN-1:0]   flag;
    } regs_t;

    // Register bit used by a pin in the enable and flag registers.
    function automatic int pin_bit(input int k);
        case (k)
            0:       return 6;
            1:       return 7;
            default: return 5;
        endcase
    endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int         W         = 3,
    parameter int         STAGES    = 2,
    parameter logic [0:0] RESET_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {(STAGES*W){RESET_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
    import ext_irq_pkg::*;
#(
    parameter bit HAS_LEVEL = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_i,
    input  logic [1:0] mode_i,
    output logic       hit_o,
    output logic       level_o
);

    logic   prev_d, prev_q;
    sense_e mode_eff;
    logic   rise, fall;

    generate
        if (HAS_LEVEL) begin : g_full
            assign mode_eff = sense_e'(mode_i);
        end else begin : g_edge_only
            assign mode_eff = sense_e'({1'b1, mode_i[0]});
        end
    endgenerate

    always_comb begin
        prev_d  = sync_i;
        rise    = sync_i & ~prev_q;
        fall    = ~sync_i & prev_q;
        hit_o   = 1'b0;
        level_o = 1'b0;
        case (mode_eff)
            SENSE_LOW:  level_o = ~sync_i;
            SENSE_ANY:  hit_o   = rise | fall;
            SENSE_FALL: hit_o   = fall;
            SENSE_RISE: hit_o   = rise;
            default:    hit_o   = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= prev_d;
        end
    end

    // R10: a pin that has not moved never produces an event, whatever the mode
    p_quiet_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(sync_i) |-> !hit_o);

    // R4: level mode never latches an event
    p_level_no_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        level_o |-> !hit_o);

endmodule

// File: rtl/ext_irq_prio.sv
module ext_irq_prio
    import ext_irq_pkg::*;
#(
    parameter int N  = NPIN,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    output logic         any_o,
    output logic [IW-1:0] idx_o
);

    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req_i[k]) begin
                idx_o = IW'(k);
            end
        end
    end

    // R9: the reported index always points at an active request
    p_grant_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> req_i[idx_o]);

    // R9: pin 0 wins whenever it requests
    p_lowest_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_i[0] |-> (idx_o == '0));

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import ext_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPIN-1:0]   pin_i,
    input  logic              global_ie,
    input  logic              ack_valid,
    input  logic [IDX_W-1:0]  ack_idx,
    output logic [NPIN-1:0]   irq_req,
    output logic              irq_any,
    output logic [IDX_W-1:0]  irq_idx
);

    regs_t           r_d, r_q;
    logic [NPIN-1:0] pin_sync;
    logic [NPIN-1:0] hit;
    logic [NPIN-1:0] level;
    logic [NPIN-1:0] src;
    logic [1:0]      mode [NPIN];

    ext_irq_sync #(.W(NPIN), .STAGES(2), .RESET_VAL(1'b1)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    genvar k;
    generate
        for (k = 0; k < NPIN; k++) begin : g_pin
            if (k < NLVL) begin : g_lvl
                assign mode[k] = r_q.sense[2*k +: 2];
                ext_irq_detect #(.HAS_LEVEL(1'b1)) i_det (
                    .clk     (clk),
                    .rst_n   (rst_n),
                    .sync_i  (pin_sync[k]),
                    .mode_i  (mode[k]),
                    .hit_o   (hit[k]),
                    .level_o (level[k])
                );
            end else begin : g_edge
                assign mode[k] = {1'b1, r_q.pol2};
                ext_irq_detect #(.HAS_LEVEL(1'b0)) i_det (
                    .clk     (clk),
                    .rst_n   (rst_n),
                    .sync_i  (pin_sync[k]),
                    .mode_i  (mode[k]),
                    .hit_o   (hit[k]),
                    .level_o (level[k])
                );
            end
        end
    endgenerate

    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            case (bus_addr)
                ADDR_EN: begin
                    for (int p = 0; p < NPIN; p++) begin
                        r_d.en[p] = bus_wdata[pin_bit(p)];
                    end
                end
                ADDR_SENSE: r_d.sense = bus_wdata[2*NLVL-1:0];
                ADDR_CTRL:  r_d.pol2  = bus_wdata[POL_BIT];
                default: ;
            endcase
        end
        for (int p = 0; p < NPIN; p++) begin
            if (hit[p]) begin
                r_d.flag[p] = 1'b1;
            end else if ((ack_valid && ack_idx == IDX_W'(p)) ||
                         (bus_wr && bus_addr == ADDR_FLAG && bus_wdata[pin_bit(p)])) begin
                r_d.flag[p] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        for (int p = 0; p < NPIN; p++) begin
            src[p] = (p < NLVL && mode[p] == SENSE_LOW) ? level[p] : r_q.flag[p];
        end
        irq_req = src & r_q.en & {NPIN{global_ie}};
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_EN: begin
                for (int p = 0; p < NPIN; p++) begin
                    bus_rdata[pin_bit(p)] = r_q.en[p];
                end
            end
            ADDR_SENSE: bus_rdata[2*NLVL-1:0] = r_q.sense;
            ADDR_CTRL:  bus_rdata[POL_BIT]    = r_q.pol2;
            default: begin
                for (int p = 0; p < NPIN; p++) begin
                    bus_rdata[pin_bit(p)] = r_q.flag[p];
                end
            end
        endcase
    end

    ext_irq_prio #(.N(NPIN), .IW(IDX_W)) i_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (irq_req),
        .any_o (irq_any),
        .idx_o (irq_idx)
    );

    // R7: no request leaves the block without the global enable
    p_req_needs_gie_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_req) |-> global_ie);

    generate
        for (k = 0; k < NPIN; k++) begin : g_chk
            // R8: an acknowledge with no competing event empties the flag
            p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (ack_valid && ack_idx == IDX_W'(k) && !hit[k]) |=> !r_q.flag[k]);
            // R8: a detected event is never lost, even against an acknowledge
            p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
                hit[k] |=> r_q.flag[k]);
            // R2: a disabled pin never requests
            p_req_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
                irq_req[k] |-> r_q.en[k]);
        end
    endgenerate

endmodule

// File: tb/test_ext_irq_ctrl.sv
`timescale 1ns/1ps
module test_ext_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [2:0] pin_i = 3'b111;
    logic       global_ie = 1'b0;
    logic       ack_valid = 1'b0;
    logic [1:0] ack_idx = '0;
    logic [2:0] irq_req;
    logic       irq_any;
    logic [1:0] irq_idx;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ext_irq_ctrl i_ext_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_i(pin_i),
        .global_ie(global_ie), .ack_valid(ack_valid), .ack_idx(ack_idx),
        .irq_req(irq_req), .irq_any(irq_any), .irq_idx(irq_idx)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        cyc(1);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input int exp, input string req);
        bus_addr = a;
        #1;
        check(req, int'(bus_rdata), exp);
    endtask

    task automatic ack(input logic [1:0] idx);
        ack_idx = idx; ack_valid = 1'b1;
        cyc(1);
        ack_valid = 1'b0;
    endtask

    task automatic t_reset;
        for (int a = 0; a < 4; a++) rd_chk(2'(a), 0, "R1 reset register");
        check("R1 reset irq_req", int'(irq_req), 0);
        check("R1 reset irq_any", int'(irq_any), 0);
    endtask

    task automatic t_regs;
        wr(2'd0, 8'hFF); rd_chk(2'd0, 8'hE0, "R2 enable bits");
        wr(2'd1, 8'hFF); rd_chk(2'd1, 8'h0F, "R3 sense bits");
        wr(2'd2, 8'hFF); rd_chk(2'd2, 8'h40, "R5 control bits");
        wr(2'd0, 8'h00); wr(2'd2, 8'h00);
        wr(2'd1, 8'h0E);
        cyc(4);
        rd_chk(2'd3, 0, "R10 no flag on mode change");
    endtask

    task automatic t_fall0;
        pin_i[0] = 1'b0;
        cyc(2); rd_chk(2'd3, 0, "R11 flag not before third edge");
        cyc(1); rd_chk(2'd3, 8'h40, "R3 falling edge pin0");
        check("R2 disabled pin no request", int'(irq_req), 0);
        wr(2'd0, 8'h40);
        check("R7 no request without gie", int'(irq_req), 0);
        global_ie = 1'b1; #1;
        check("R7 request with gie", int'(irq_req), 1);
        check("R9 index pin0", int'(irq_idx), 0);
        wr(2'd3, 8'h00); rd_chk(2'd3, 8'h40, "R6 write zero keeps flag");
        wr(2'd3, 8'hBF); rd_chk(2'd3, 8'h40, "R6 other ones keep flag");
        wr(2'd3, 8'h40); rd_chk(2'd3, 0, "R6 write one clears");
        check("R6 request gone", int'(irq_req), 0);
    endtask

    task automatic t_rise1;
        pin_i[1] = 1'b0;
        cyc(4); rd_chk(2'd3, 0, "R3 falling ignored in rising mode");
        pin_i[1] = 1'b1;
        cyc(3); rd_chk(2'd3, 8'h80, "R3 rising edge pin1");
    endtask

    task automatic t_any0;
        wr(2'd1, 8'h0D);
        pin_i[0] = 1'b1;
        cyc(3); rd_chk(2'd3, 8'hC0, "R3 any change rise");
        wr(2'd3, 8'h40); rd_chk(2'd3, 8'h80, "R6 clear pin0 only");
        pin_i[0] = 1'b0;
        cyc(3); rd_chk(2'd3, 8'hC0, "R3 any change fall");
    endtask

    task automatic t_ack;
        wr(2'd0, 8'hE0);
        check("R9 pin0 before pin1", int'(irq_idx), 0);
        check("R9 any", int'(irq_any), 1);
        ack(2'd0);
        rd_chk(2'd3, 8'h80, "R8 ack clears pin0");
        check("R9 pin1 next", int'(irq_idx), 1);
        pin_i[0] = 1'b1;
        cyc(2);
        ack(2'd0);
        rd_chk(2'd3, 8'hC0, "R8 new edge beats ack");
        ack(2'd1); rd_chk(2'd3, 8'h40, "R8 ack pin1");
        ack(2'd0); rd_chk(2'd3, 8'h00, "R8 ack pin0");
    endtask

    task automatic t_int2;
        pin_i[2] = 1'b0;
        cyc(3); rd_chk(2'd3, 8'h20, "R5 falling pin2");
        check("R9 only pin2", int'(irq_idx), 2);
        wr(2'd3, 8'h20);
        wr(2'd2, 8'h40);
        cyc(2); rd_chk(2'd3, 0, "R10 polarity change no flag");
        pin_i[2] = 1'b1;
        cyc(3); rd_chk(2'd3, 8'h20, "R5 rising pin2");
        pin_i[0] = 1'b0;
        cyc(3); rd_chk(2'd3, 8'h60, "R3 pin0 with pin2");
        check("R9 pin0 over pin2", int'(irq_idx), 0);
        wr(2'd0, 8'hA0); #1;
        check("R9 masked pin0 gives pin2", int'(irq_idx), 2);
        wr(2'd3, 8'hE0); rd_chk(2'd3, 0, "R6 clear all");
    endtask

    task automatic t_level;
        wr(2'd0, 8'hE0);
        wr(2'd1, 8'h0C); #1;
        check("R4 low level requests", int'(irq_req), 1);
        cyc(3); rd_chk(2'd3, 0, "R4 level not latched");
        ack(2'd0); #1;
        check("R4 ack keeps level request", int'(irq_req), 1);
        global_ie = 1'b0; #1;
        check("R7 gie gates level", int'(irq_any), 0);
        global_ie = 1'b1;
        pin_i[0] = 1'b1;
        cyc(1); check("R11 level still seen", int'(irq_req), 1);
        cyc(1); check("R4 level released", int'(irq_req), 0);
        rd_chk(2'd3, 0, "R4 no flag after level");
    endtask

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_regs();
        t_fall0();
        t_rise1();
        t_any0();
        t_ack();
        t_int2();
        t_level();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule